// File: doc/BRIEF.md
# Precise Exception Ordering Unit

This block tracks the instructions of a five-stage pipeline (fetch, decode, execute, memory, write-back) and makes their exceptions precise. A fault raised by the fetch, execute or memory stage is not serviced when it is raised. It is recorded in a three-bit status word that travels with the instruction, together with its valid bit and its address. The status word is examined only when the instruction reaches write-back. Faults are therefore taken in program order, whatever cycle they were raised in.

When the instruction in write-back carries a non-zero status word, the block takes the exception in that cycle. The faulting instruction does not commit. Every younger instruction is squashed, and every older one has already retired. The faulting address is saved as the restart point, and a cause code is saved. Fetch then continues from a fixed handler address. The surrounding pipeline uses `valid_o`, `commit_o` and `mem_we_o` to gate its register-file and memory writes.

Top module: `precise_exc_unit`

## Requirements
- R1: While reset is held and after its release, `valid_o` is 0, `pc_o` equals RESET_PC, and `epc_o` and `cause_o` are 0.
- R2: When no exception is taken, `pc_o` advances by PC_STEP on each clock edge where `fetch_en_i` is high, and holds its value otherwise.
- R3: A fetched instruction occupies valid bit 0 (fetch) the cycle after `pc_o` held its address. It moves up one bit per cycle through bit 1 (decode), bit 2 (execute) and bit 3 (memory) to bit 4 (write-back). In write-back, `commit_pc_o` carries its address.
- R4: A fault input marks only the instruction in the stage it belongs to. `fault_if_i` marks fetch, `fault_ex_i` marks execute and `fault_mem_i` marks memory. It causes no flush until that instruction reaches write-back. Fault inputs that arrive while the stage is empty have no effect.
- R5: `exc_o` is high exactly when the write-back instruction is valid and marked. `commit_o` is high exactly when it is valid and unmarked, so the faulting instruction never commits.
- R6: On the clock edge where `exc_o` is high, every valid bit is cleared.
- R7: On the clock edge after `exc_o` was high, `pc_o` equals HANDLER_PC.
- R8: On the clock edge where `exc_o` is high, `epc_o` takes the address of the faulting instruction.
- R9: `cause_o` takes the lowest set mark of the faulting instruction: 0 for fetch, 1 for execute, 2 for memory. Fetch wins within one instruction.
- R10: When several instructions are marked at once, the oldest is taken. An older memory fault is taken even if younger instructions fault in execute and fetch in the same cycle.
- R11: `mem_we_o` is high only for a valid, unmarked instruction in memory that has no memory fault this cycle, in a cycle with no exception taken.
- R12: Instructions older than a faulting one commit normally before the exception is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en_i | input | 1 | Fetch the instruction at `pc_o` on this edge |
| fault_if_i | input | 1 | Fault for the instruction in fetch |
| fault_ex_i | input | 1 | Fault for the instruction in execute |
| fault_mem_i | input | 1 | Fault for the instruction in memory |
| pc_o | output | XLEN | Next fetch address |
| valid_o | output | 5 | Stage valid bits, bit 0 fetch to bit 4 write-back |
| mem_we_o | output | 1 | Memory-stage write permitted |
| commit_o | output | 1 | Write-back instruction retires |
| commit_pc_o | output | XLEN | Address of the write-back instruction |
| exc_o | output | 1 | Exception taken this cycle |
| epc_o | output | XLEN | Saved restart address |
| cause_o | output | 2 | Saved cause code |

## Verification
A status word attached to the wrong instruction, or lost while shifting, appears at the ports four cycles or fewer after the fault input. It shows as a wrong `exc_o`, `commit_o` or `epc_o` when that instruction reaches write-back. A missed squash shows one cycle later as a non-zero `valid_o`, and later still as a stray commit. A wrong fetch counter shows in `pc_o` on the next edge. The bench compares every output against a queue-based model on every cycle, so each of these faults is reported in the first cycle it becomes visible.

// File: rtl/precise_exc_unit.sv
module precise_exc_unit #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter logic [XLEN-1:0] HANDLER_PC = 'h100,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_en_i,
  input  logic            fault_if_i,
  input  logic            fault_ex_i,
  input  logic            fault_mem_i,
  output logic [XLEN-1:0] pc_o,
  output logic [4:0]      valid_o,
  output logic            mem_we_o,
  output logic            commit_o,
  output logic [XLEN-1:0] commit_pc_o,
  output logic            exc_o,
  output logic [XLEN-1:0] epc_o,
  output logic [1:0]      cause_o
);
  localparam int NST = 5;
  localparam int WB = NST - 1;
  localparam int MEM = NST - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  logic [XLEN-1:0] pc_q, epc_q;
  logic [1:0]      cause_q;
  logic [NST-1:0]  v;
  logic [XLEN-1:0] spc [NST];
  logic [2:0]      mark [NST];
  logic            take;
  logic [1:0]      cause_n;

  assign take     = v[WB] & (|mark[WB]);
  assign cause_n  = mark[WB][0] ? 2'd0 : (mark[WB][1] ? 2'd1 : 2'd2);
  assign pc_o     = pc_q;
  assign valid_o  = v;
  assign exc_o    = take;
  assign commit_o = v[WB] & ~(|mark[WB]);
  assign commit_pc_o = spc[WB];
  assign mem_we_o = v[MEM] & ~(|mark[MEM]) & ~fault_mem_i & ~take;
  assign epc_o    = epc_q;
  assign cause_o  = cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      epc_q   <= '0;
      cause_q <= '0;
      v       <= '0;
      for (int i = 0; i < NST; i++) begin
        spc[i]  <= '0;
        mark[i] <= '0;
      end
    end else if (take) begin
      v       <= '0;
      pc_q    <= HANDLER_PC;
      epc_q   <= spc[WB];
      cause_q <= cause_n;
    end else begin
      v       <= {v[NST-2:0], fetch_en_i};
      spc[0]  <= pc_q;
      mark[0] <= '0;
      spc[1]  <= spc[0];
      mark[1] <= mark[0] | {2'b00, fault_if_i};
      spc[2]  <= spc[1];
      mark[2] <= mark[1];
      spc[3]  <= spc[2];
      mark[3] <= mark[2] | {1'b0, fault_ex_i, 1'b0};
      spc[4]  <= spc[3];
      mark[4] <= mark[3] | {fault_mem_i, 2'b00};
      if (fetch_en_i) pc_q <= pc_q + STEP;
    end
  end
endmodule

module precise_exc_unit_chk #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 'h100
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_en_i,
  input logic [XLEN-1:0] pc_o,
  input logic [4:0]      valid_o,
  input logic            mem_we_o,
  input logic            commit_o,
  input logic [XLEN-1:0] commit_pc_o,
  input logic            exc_o,
  input logic [XLEN-1:0] epc_o
);
  // R5
  commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(exc_o && commit_o));
  // R6
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n) exc_o |=> (valid_o == 5'b0));
  // R7
  handler_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n) exc_o |=> (pc_o == HANDLER_PC));
  // R8
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n) exc_o |=> (epc_o == $past(commit_pc_o)));
  // R11
  no_store_on_flush_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we_o |-> (!exc_o && valid_o[3]));
  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!exc_o && !fetch_en_i) |=> $stable(pc_o));
  // R3
  advance_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n) (valid_o[3] && !exc_o) |=> valid_o[4]);
endmodule

bind precise_exc_unit precise_exc_unit_chk #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_en_i(fetch_en_i), .pc_o(pc_o), .valid_o(valid_o),
  .mem_we_o(mem_we_o), .commit_o(commit_o), .commit_pc_o(commit_pc_o), .exc_o(exc_o),
  .epc_o(epc_o)
);

// File: tb/tb_precise_exc_unit.sv
`timescale 1ns/1ps
module tb_precise_exc_unit;
  localparam logic [31:0] RST_PC = 32'h0;
  localparam logic [31:0] HND_PC = 32'h100;

  logic clk = 0, rst_n = 0;
  logic fetch_en_i = 0, fault_if_i = 0, fault_ex_i = 0, fault_mem_i = 0;
  logic [31:0] pc_o, commit_pc_o, epc_o;
  logic [4:0] valid_o;
  logic mem_we_o, commit_o, exc_o;
  logic [1:0] cause_o;

  precise_exc_unit #(.XLEN(32), .RESET_PC(RST_PC), .HANDLER_PC(HND_PC), .PC_STEP(4)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_en_i(fetch_en_i), .fault_if_i(fault_if_i),
    .fault_ex_i(fault_ex_i), .fault_mem_i(fault_mem_i), .pc_o(pc_o), .valid_o(valid_o),
    .mem_we_o(mem_we_o), .commit_o(commit_o), .commit_pc_o(commit_pc_o), .exc_o(exc_o),
    .epc_o(epc_o), .cause_o(cause_o));

  always #2.5 clk = ~clk;

  typedef struct { logic [31:0] pc; logic [2:0] vec; int age; } ent_t;
  ent_t q[$];
  logic [31:0] m_pc = RST_PC, m_epc = 0;
  logic [1:0] m_cause = 0;
  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic last_commit;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit fe, input bit fi, input bit fx, input bit fm);
    logic [4:0] ev;
    int wi, mi;
    bit tk;
    @(negedge clk);
    fetch_en_i = fe; fault_if_i = fi; fault_ex_i = fx; fault_mem_i = fm;
    #1;
    ev = 0; wi = -1; mi = -1;
    foreach (q[i]) begin
      ev[q[i].age] = 1'b1;
      if (q[i].age == 4) wi = i;
      if (q[i].age == 3) mi = i;
    end
    tk = (wi >= 0) && (q[wi].vec != 0);
    chk("R2 R7 pc_o", pc_o, m_pc);
    chk("R3 R6 valid_o", {27'b0, valid_o}, {27'b0, ev});
    chk("R4 R5 R10 exc_o", {31'b0, exc_o}, {31'b0, tk});
    chk("R5 R12 commit_o", {31'b0, commit_o}, {31'b0, (wi >= 0) && !tk});
    if (wi >= 0) chk("R3 commit_pc_o", commit_pc_o, q[wi].pc);
    chk("R11 mem_we_o", {31'b0, mem_we_o},
        {31'b0, (mi >= 0) && (q[mi].vec == 0) && !fm && !tk});
    chk("R8 epc_o", epc_o, m_epc);
    chk("R9 cause_o", {30'b0, cause_o}, {30'b0, m_cause});
    last_commit = commit_o;
    @(posedge clk);
    if (tk) begin
      m_epc = q[wi].pc;
      m_cause = q[wi].vec[0] ? 2'd0 : (q[wi].vec[1] ? 2'd1 : 2'd2);
      q.delete();
      m_pc = HND_PC;
    end else begin
      if (wi >= 0) q.delete(wi);
      foreach (q[i]) begin
        if (q[i].age == 0 && fi) q[i].vec[0] = 1'b1;
        if (q[i].age == 2 && fx) q[i].vec[1] = 1'b1;
        if (q[i].age == 3 && fm) q[i].vec[2] = 1'b1;
        q[i].age++;
      end
      if (fe) begin
        q.push_back('{pc: m_pc, vec: 3'b0, age: 0});
        m_pc = m_pc + 4;
      end
    end
  endtask

  function automatic logic [31:0] pc_at_age(input int a);
    logic [31:0] r = 32'hx;
    foreach (q[i]) if (q[i].age == a) r = q[i].pc;
    return r;
  endfunction

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] target;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 valid in reset", {27'b0, valid_o}, 32'h0);
    chk("R1 pc in reset", pc_o, RST_PC);
    rst_n = 1;
    #1;
    chk("R1 epc after reset", epc_o, 32'h0);
    chk("R1 cause after reset", {30'b0, cause_o}, 32'h0);

    fill(12);
    for (int i = 0; i < 10; i++) cyc(i % 2, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0);
    // R4 faults on an empty pipeline are ignored
    cyc(0, 1, 1, 1);
    cyc(0, 0, 0, 0);
    chk("R4 empty-stage fault ignored", {31'b0, exc_o}, 32'h0);

    fill(6);
    cyc(1, 0, 1, 0);
    fill(6);
    chk("R9 execute cause", {30'b0, cause_o}, 32'd1);

    // R10 older memory fault beats younger faults raised together
    fill(6);
    target = pc_at_age(3);
    cyc(1, 1, 1, 1);
    chk("R12 older instruction commits", {31'b0, last_commit}, 32'h1);
    cyc(1, 0, 0, 0);
    #1;
    chk("R10 oldest fault taken epc", epc_o, target);
    chk("R10 memory cause", {30'b0, cause_o}, 32'd2);
    fill(6);

    // R9 fetch beats memory within one instruction
    fill(4);
    target = m_pc;
    cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 1);
    cyc(1, 0, 0, 0);
    #1;
    chk("R9 fetch priority cause", {30'b0, cause_o}, 32'd0);
    chk("R8 epc fetch+mem", epc_o, target);

    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 4) != 0, ($urandom % 25) == 0, ($urandom % 25) == 0, ($urandom % 25) == 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule